// File: doc/BRIEF.md
# Serial Audio Output Port with Chain Pass-Through

This block turns a parallel stereo pair of 24-bit two's-complement samples into a single serial data line. The bit clock and the frame clock come from outside. Both are oversampled by the block's own system clock, so the system clock must run several times faster than the bit clock. Four framings are available: left-justified, I2S, right-justified, and a time-division multiplexed (TDM) frame. The TDM frame carries this device's two slots first and then the bits that arrive on a chain input, so that several devices can share one line into a DSP.

A two-bit code picks the output word length: 24, 20, 18 or 16 bits. When the word is shorter than 24 bits, triangular dither and a half-LSB rounding offset are added to the sample. The result is saturated and its unused low bits are cleared. Samples are offered with a one-cycle valid strobe and wait in a holding register. A waiting pair is taken up at the start of the next frame. If no new pair has arrived by then, the last pair is sent again.

Top module: `serial_audio_tx`

## Requirements
- R1: After reset `sdout_o` is low, and it stays low until the first frame start is detected.
- R2: Framing code 00 is left-justified. The left word is sent while the frame clock is high. Its MSB goes out in the first bit period after the frame clock changes level, with bits in MSB-first order. The slot is padded with zeros up to the end of the 32-bit half-frame.
- R3: Framing code 01 is I2S. The left word is sent while the frame clock is low. The MSB goes out in the second bit period after the frame clock changes level.
- R4: Framing code 11 is right-justified. The word is placed at the end of a 32-bit half-frame, so its LSB goes out in the 32nd bit period. The leading bit periods are zero.
- R5: Framing code 10 is TDM. A frame starts at a bit-clock falling edge that sees the frame clock high after it was low at the previous falling edge. The left word fills bit periods 0 to 31 of the frame and the right word fills periods 32 to 63, each MSB first and zero-padded.
- R6: `chain_i` is sampled at every bit-clock falling edge. In TDM, from bit period 64 of a frame onward, the output repeats the chain bit sampled 64 bit periods earlier. In the other framings `chain_i` never reaches the output.
- R7: Word-length code 00 selects 24 bits, 01 selects 20, 10 selects 18 and 11 selects 16. With 24 bits the sample is sent unchanged.
- R8: For 20, 18 or 16 bits, the sent word carries zeros below its length. It lies within 1.5 of its own LSB of the input sample. Because of the dither, repeated frames of the same sample do not all carry the same word.
- R9: A result above positive full scale saturates. For input 0x7FFFFF at 16 bits, the word sent is 0x7FFF.
- R10: A pair offered with `smp_vld_i` in the middle of a frame does not change that frame. It is sent from the next frame start.
- R11: When no new pair is offered before a frame start, the previous pair is sent again.
- R12: `sdout_o` changes only in the system-clock cycles that follow a bit-clock falling edge, and it settles within three system-clock cycles of that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Output bit clock, externally supplied |
| fclk_i | input | 1 | Frame clock: left/right select, or frame-sync pulse in TDM |
| chain_i | input | 1 | Daisy-chain serial data, used in TDM only; tie low when unused |
| fmt_i | input | 2 | Framing code: 00 LJ, 01 I2S, 10 TDM, 11 RJ |
| wlen_i | input | 2 | Word-length code: 00 24, 01 20, 10 18, 11 16 bits |
| smp_vld_i | input | 1 | One-cycle strobe that offers a new sample pair |
| smp_l_i | input | 24 | Left sample, two's complement |
| smp_r_i | input | 24 | Right sample, two's complement |
| sdout_o | output | 1 | Serial data output, updated after bit-clock falling edges |

## Verification
The assertions rely on the following input conditions:
- Each bit-clock phase lasts at least a few system-clock cycles, so that every falling edge produces exactly one edge strobe.
- The frame clock and chain input change only while the bit clock is high.
- The framing code does not change in the middle of a frame.

The stimulus meets these conditions. Each bit-clock phase is held for eight system-clock cycles, and the frame clock and chain input are driven while the bit clock is high. The framing code and word-length code are changed only between frames. Before each first frame, idle bit periods at the right-channel level are sent so that the frame start is a real level change.

// File: rtl/serial_audio_tx.sv
module serial_audio_tx #(
  parameter int SLOT = 32,
  parameter int CW = 10,
  parameter logic [23:0] SEED = 24'h9E3779
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bclk_i,
  input  logic        fclk_i,
  input  logic        chain_i,
  input  logic [1:0]  fmt_i,
  input  logic [1:0]  wlen_i,
  input  logic        smp_vld_i,
  input  logic [23:0] smp_l_i,
  input  logic [23:0] smp_r_i,
  output logic        sdout_o
);
  localparam int FRAME = 2 * SLOT;
  localparam logic [1:0] F_I2S = 2'b01;
  localparam logic [1:0] F_TDM = 2'b10;
  localparam logic [1:0] F_RJ  = 2'b11;

  logic          b1, b2, f1, c1;
  logic          fprev_q, seen_q, run_q, ch_q, fall_d;
  logic [CW-1:0] cnt_q;
  logic [FRAME:0] csr_q;
  logic          pend_v;
  logic [23:0]   pend_l, pend_r, act_l, act_r, proc_l, proc_r, lfsr_q;
  logic [1:0]    wl_q;
  logic          nxt;

  function automatic logic [23:0] lfsr_step(input logic [23:0] s);
    return {s[22:0], s[23] ^ s[22] ^ s[21] ^ s[16]};
  endfunction

  function automatic logic [23:0] low_mask(input logic [1:0] wl);
    case (wl)
      2'b01:   return 24'h00000F;
      2'b10:   return 24'h00003F;
      2'b11:   return 24'h0000FF;
      default: return 24'h000000;
    endcase
  endfunction

  function automatic int word_bits(input logic [1:0] wl);
    case (wl)
      2'b01:   return 20;
      2'b10:   return 18;
      2'b11:   return 16;
      default: return 24;
    endcase
  endfunction

  function automatic logic [23:0] shorten(input logic [23:0] x, input logic [1:0] wl,
                                          input logic [23:0] ra, input logic [23:0] rb);
    logic [23:0] m, half, res;
    logic signed [26:0] acc;
    m = low_mask(wl);
    half = m ^ (m >> 1);
    acc = $signed({{3{x[23]}}, x}) + $signed({3'b000, ra & m})
        - $signed({3'b000, rb & m}) + $signed({3'b000, half});
    if (acc > 27'sd8388607) res = 24'h7FFFFF;
    else if (acc < -27'sd8388608) res = 24'h800000;
    else res = acc[23:0];
    return res & ~m;
  endfunction

  wire fall     = b2 & ~b1;
  wire tdm      = (fmt_i == F_TDM);
  wire left_lvl = (fmt_i != F_I2S);
  wire f_edge   = seen_q && (f1 != fprev_q);
  wire fstart   = fall && f_edge && (tdm ? f1 : (f1 == left_lvl));
  wire restart  = fall && (tdm ? fstart : f_edge);

  wire [23:0] src_l = pend_v ? pend_l : act_l;
  wire [23:0] src_r = pend_v ? pend_r : act_r;
  wire [23:0] s1 = lfsr_step(lfsr_q);
  wire [23:0] s2 = lfsr_step(s1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b1 <= 1'b0; b2 <= 1'b0; f1 <= 1'b0; c1 <= 1'b0;
      fall_d <= 1'b0;
    end else begin
      b1 <= bclk_i; b2 <= b1; f1 <= fclk_i; c1 <= chain_i;
      fall_d <= fall;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fprev_q <= 1'b0; seen_q <= 1'b0; ch_q <= 1'b0;
      cnt_q <= '0; csr_q <= '0;
    end else if (fall) begin
      fprev_q <= f1;
      seen_q  <= 1'b1;
      ch_q    <= (f1 != left_lvl);
      csr_q   <= {csr_q[FRAME-1:0], c1};
      if (restart) cnt_q <= '0;
      else if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0; pend_l <= '0; pend_r <= '0;
    end else if (smp_vld_i) begin
      pend_v <= 1'b1; pend_l <= smp_l_i; pend_r <= smp_r_i;
    end else if (fstart) begin
      pend_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; act_l <= '0; act_r <= '0;
      proc_l <= '0; proc_r <= '0; wl_q <= 2'b00; lfsr_q <= SEED;
    end else if (fstart) begin
      run_q  <= 1'b1;
      act_l  <= src_l;
      act_r  <= src_r;
      wl_q   <= wlen_i;
      proc_l <= shorten(src_l, wlen_i, lfsr_q, s1);
      proc_r <= shorten(src_r, wlen_i, s2, {s1[11:0], s1[23:12]});
      lfsr_q <= s2;
    end
  end

  always_comb begin
    int n, pos, off, w;
    logic [23:0] word;
    n = int'(cnt_q);
    w = word_bits(wl_q);
    word = proc_l;
    nxt = 1'b0;
    case (fmt_i)
      F_I2S:   off = 1;
      F_RJ:    off = SLOT - w;
      default: off = 0;
    endcase
    if (tdm && n >= FRAME) begin
      nxt = csr_q[FRAME];
    end else begin
      if (tdm ? (n >= SLOT) : ch_q) word = proc_r;
      pos = (tdm && n >= SLOT) ? n - SLOT - off : n - off;
      if (pos >= 0 && pos < w) nxt = word[5'(23 - pos)];
    end
    nxt = nxt & run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sdout_o <= 1'b0;
    else if (fall_d) sdout_o <= nxt;
  end
endmodule

// File: rtl/audio_tx_chk.sv
module audio_tx_chk #(
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sdout_o,
  input logic          fall,
  input logic          fstart,
  input logic          run_q,
  input logic [CW-1:0] cnt_q,
  input logic [23:0]   proc_l,
  input logic [23:0]   proc_r,
  input logic [1:0]    wl_q
);
  AST_QUIET_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !sdout_o); // R1
  AST_CNT_ZERO_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    fstart |=> (cnt_q == '0)); // R5
  AST_LOW_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wl_q == 2'b11) |-> (proc_l[7:0] == 8'h00 && proc_r[7:0] == 8'h00)); // R8
  AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fstart |=> ($stable(proc_l) && $stable(proc_r))); // R10
  AST_DATA_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout_o) |-> $past(fall, 2)); // R12
endmodule

bind serial_audio_tx audio_tx_chk #(.CW(CW)) u_chk (.*);

// File: tb/sim_serial_audio_tx.sv
`timescale 1ns/1ps
module sim_serial_audio_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk_i = 1'b1, fclk_i = 1'b0, chain_i = 1'b0;
  logic [1:0] fmt_i = 2'b00, wlen_i = 2'b00;
  logic smp_vld_i = 1'b0;
  logic [23:0] smp_l_i = '0, smp_r_i = '0;
  logic sdout_o;

  int checks = 0, fails = 0, r12_bad = 0;
  logic last_s = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  serial_audio_tx u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_per(input logic f, input logic c, output logic s);
    fclk_i = f; chain_i = c;
    repeat (8) @(negedge clk);
    if (sdout_o !== last_s) r12_bad++;
    bclk_i = 1'b0;
    repeat (8) @(negedge clk);
    s = sdout_o;
    last_s = s;
    bclk_i = 1'b1;
  endtask

  task automatic push(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    smp_l_i = l; smp_r_i = r; smp_vld_i = 1'b1;
    @(negedge clk);
    smp_vld_i = 1'b0;
  endtask

  task automatic idle(input int n, input logic f);
    logic s;
    for (int p = 0; p < n; p++) bit_per(f, 1'b0, s);
  endtask

  task automatic run_frame(input int n, input logic is_tdm, input logic lvl, input logic [63:0] cp,
                           input int push_at, input logic [23:0] pl, input logic [23:0] pr,
                           output logic [127:0] got);
    logic s, f, c;
    got = '0;
    for (int p = 0; p < n; p++) begin
      if (p == push_at) push(pl, pr);
      f = is_tdm ? (p == 0) : ((p < n / 2) ? lvl : ~lvl);
      c = is_tdm ? ((p < 64) ? cp[63 - p] : 1'b0) : 1'b1;
      bit_per(f, c, s);
      got[127 - p] = s;
    end
  endtask

  function automatic logic [31:0] slot_exp(input int off, input int w, input logic [23:0] word);
    logic [31:0] v;
    int pos;
    v = '0;
    for (int p = 0; p < 32; p++) begin
      pos = p - off;
      if (pos >= 0 && pos < w) v[31 - p] = word[23 - pos];
    end
    return v;
  endfunction

  task automatic chk_short(input string req, input logic [31:0] slot, input logic [23:0] x,
                           input int w, output logic [23:0] v);
    int k, diff;
    logic [23:0] lowm;
    bit ok;
    k = 24 - w;
    lowm = 24'((1 << k) - 1);
    v = slot[31:8];
    diff = int'($signed(v)) - int'($signed(x));
    if (diff < 0) diff = -diff;
    ok = (slot[7:0] == 8'h00) && ((v & lowm) == 24'h0) && (diff <= (3 * (1 << k)) / 2);
    chk(ok, req, {104'h0, v}, {104'h0, x});
  endtask

  task automatic t_reset;
    logic s;
    int bad;
    chk(sdout_o === 1'b0, "R1 reset", {127'h0, sdout_o}, 128'h0);
    bad = 0;
    for (int p = 0; p < 3; p++) begin
      bit_per(1'b0, 1'b1, s);
      if (s !== 1'b0) bad++;
    end
    chk(bad == 0, "R1 quiet before frame start", 128'(bad), 128'h0);
  endtask

  task automatic t_lj;
    logic [127:0] g;
    fmt_i = 2'b00; wlen_i = 2'b00;
    push(24'hA5C3F1, 24'h1E6B92);
    run_frame(64, 1'b0, 1'b1, '0, -1, '0, '0, g);
    chk(g[127:96] == slot_exp(0, 24, 24'hA5C3F1), "R2 R7 LJ left", {96'h0, g[127:96]},
        {96'h0, slot_exp(0, 24, 24'hA5C3F1)});
    chk(g[95:64] == slot_exp(0, 24, 24'h1E6B92), "R2 LJ right", {96'h0, g[95:64]},
        {96'h0, slot_exp(0, 24, 24'h1E6B92)});
    chk(g[103:96] == 8'h00 && g[71:64] == 8'h00, "R6 chain ignored outside TDM",
        {112'h0, g[103:96], g[71:64]}, 128'h0);
  endtask

  task automatic t_repeat;
    logic [127:0] g;
    run_frame(64, 1'b0, 1'b1, '0, -1, '0, '0, g);
    chk(g[127:64] == {slot_exp(0, 24, 24'hA5C3F1), slot_exp(0, 24, 24'h1E6B92)}, "R11 repeat pair",
        {64'h0, g[127:64]}, {64'h0, slot_exp(0, 24, 24'hA5C3F1), slot_exp(0, 24, 24'h1E6B92)});
  endtask

  task automatic t_midframe;
    logic [127:0] g;
    run_frame(64, 1'b0, 1'b1, '0, 40, 24'h0F0F0F, 24'hF00F55, g);
    chk(g[127:64] == {slot_exp(0, 24, 24'hA5C3F1), slot_exp(0, 24, 24'h1E6B92)}, "R10 mid-frame unchanged",
        {64'h0, g[127:64]}, {64'h0, slot_exp(0, 24, 24'hA5C3F1), slot_exp(0, 24, 24'h1E6B92)});
    run_frame(64, 1'b0, 1'b1, '0, -1, '0, '0, g);
    chk(g[127:64] == {slot_exp(0, 24, 24'h0F0F0F), slot_exp(0, 24, 24'hF00F55)}, "R10 next frame new pair",
        {64'h0, g[127:64]}, {64'h0, slot_exp(0, 24, 24'h0F0F0F), slot_exp(0, 24, 24'hF00F55)});
  endtask

  task automatic t_i2s;
    logic [127:0] g;
    fmt_i = 2'b01;
    push(24'h8137EC, 24'h7B2D40);
    idle(2, 1'b1);
    run_frame(64, 1'b0, 1'b0, '0, -1, '0, '0, g);
    chk(g[127:64] == {slot_exp(1, 24, 24'h8137EC), slot_exp(1, 24, 24'h7B2D40)}, "R3 I2S frame",
        {64'h0, g[127:64]}, {64'h0, slot_exp(1, 24, 24'h8137EC), slot_exp(1, 24, 24'h7B2D40)});
  endtask

  task automatic t_rj;
    logic [127:0] g;
    fmt_i = 2'b11; wlen_i = 2'b00;
    push(24'hC0FFEE, 24'h3A5A5A);
    idle(2, 1'b0);
    run_frame(64, 1'b0, 1'b1, '0, -1, '0, '0, g);
    chk(g[127:64] == {slot_exp(8, 24, 24'hC0FFEE), slot_exp(8, 24, 24'h3A5A5A)}, "R4 RJ 24-bit",
        {64'h0, g[127:64]}, {64'h0, slot_exp(8, 24, 24'hC0FFEE), slot_exp(8, 24, 24'h3A5A5A)});
    wlen_i = 2'b11;
    push(24'h7FFFFF, 24'h7FFFFF);
    run_frame(64, 1'b0, 1'b1, '0, -1, '0, '0, g);
    chk(g[127:64] == {slot_exp(16, 16, 24'h7FFF00), slot_exp(16, 16, 24'h7FFF00)}, "R4 R9 RJ 16-bit saturate",
        {64'h0, g[127:64]}, {64'h0, slot_exp(16, 16, 24'h7FFF00), slot_exp(16, 16, 24'h7FFF00)});
  endtask

  task automatic t_tdm;
    logic [127:0] g;
    logic [63:0] cp;
    cp = 64'hC3A5_0F1E_9B27_4D86;
    fmt_i = 2'b10; wlen_i = 2'b00;
    push(24'h5DE0B3, 24'hE24C17);
    idle(2, 1'b0);
    run_frame(128, 1'b1, 1'b0, cp, -1, '0, '0, g);
    chk(g[127:96] == slot_exp(0, 24, 24'h5DE0B3), "R5 TDM left slot", {96'h0, g[127:96]},
        {96'h0, slot_exp(0, 24, 24'h5DE0B3)});
    chk(g[95:64] == slot_exp(0, 24, 24'hE24C17), "R5 TDM right slot", {96'h0, g[95:64]},
        {96'h0, slot_exp(0, 24, 24'hE24C17)});
    chk(g[63:0] == cp, "R6 TDM chain after 64 bits", {64'h0, g[63:0]}, {64'h0, cp});
  endtask

  task automatic t_dither;
    logic [127:0] g;
    logic [23:0] v, first;
    bit varied;
    fmt_i = 2'b00; wlen_i = 2'b11;
    push(24'h123480, 24'hFFDCBB);
    idle(2, 1'b0);
    varied = 0;
    first = '0;
    for (int i = 0; i < 16; i++) begin
      run_frame(64, 1'b0, 1'b1, '0, -1, '0, '0, g);
      chk_short("R8 R7 16-bit left", g[127:96], 24'h123480, 16, v);
      if (i == 0) first = v;
      else if (v != first) varied = 1;
      chk_short("R8 16-bit right", g[95:64], 24'hFFDCBB, 16, v);
    end
    chk(varied, "R8 dither varies", 128'(varied), 128'h1);
    wlen_i = 2'b01;
    run_frame(64, 1'b0, 1'b1, '0, -1, '0, '0, g);
    chk_short("R7 R8 20-bit", g[127:96], 24'h123480, 20, v);
    wlen_i = 2'b10;
    run_frame(64, 1'b0, 1'b1, '0, -1, '0, '0, g);
    chk_short("R7 R8 18-bit", g[127:96], 24'h123480, 18, v);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_lj;
    t_repeat;
    t_midframe;
    t_i2s;
    t_rj;
    t_tdm;
    t_dither;
    chk(r12_bad == 0, "R12 output stable away from falling edge", 128'(r12_bad), 128'h0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule